// File: doc/BRIEF.md
# Quadrature-stepped Gray code counter

This block keeps an up/down count whose state is a Gray code word, and moves that word with two quadrature phase bits instead of a binary adder. Single-cycle step pulses on an up input and a down input first walk a 2-bit quadrature pair through its four states. Each step moves exactly one of the two phases. The low phase is itself the least significant bit of the Gray word. When the other phase moves, the block writes one of the upper Gray bits in the following cycle.

That upper bit is selected by a position rule, and the value written is a parity. A combinational Gray-to-binary stage then gives the count in binary. Reset returns everything to zero, and the count wraps in both directions. The quadrature phases, the Gray word and the binary word are all visible on the ports.

The Gray and binary outputs settle one cycle after the phase change. When steps arrive back to back on consecutive cycles, the outputs are correct once the inputs have been idle for one cycle.

Top module: `quad_gray_counter`

## Requirements
- R1: While `rst_n` is low, `ph_lo`, `ph_hi`, `gray` and `bin` are all zero.
- R2: A cycle with `step_up` high and `step_down` low moves the pair {`ph_lo`,`ph_hi`} (`ph_lo` written first) through 00, 10, 11, 01, then back to 00. Exactly one of the two phases changes at the next clock edge.
- R3: A cycle with `step_down` high and `step_up` low walks the same four states in the reverse order, again changing exactly one phase.
- R4: A cycle in which both step inputs are high, or both are low, leaves both phases unchanged.
- R5: Bit 0 of `gray` always equals `ph_lo`.
- R6: Bits `gray[N-1:1]` change only on the clock edge that follows an edge at which `ph_hi` changed. In the cycle between those two edges, they still hold their old value.
- R7: On that update, one upper bit is written. It is the bit just above the lowest set bit of `gray[N-2:0]`, or the MSB if `gray[N-2:0]` is zero. The value written is the XOR of `ph_hi` with every other bit of `gray[N-1:1]`. `ph_lo` is not part of the XOR.
- R8: Once the inputs have been idle for a cycle after k net up steps (up steps minus down steps), `gray` equals k XOR (k >> 1) modulo 2^N.
- R9: The count wraps in both directions. One up step from all-ones binary gives zero, and one down step from zero gives all-ones.
- R10: The MSB of `bin` equals the MSB of `gray`. Each lower bit of `bin` is the XOR of the matching `gray` bit and the next-higher `bin` bit.
- R11: From one cycle to the next, at most one bit of `gray[N-1:1]` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| step_up | input | 1 | One-cycle pulse per upward step |
| step_down | input | 1 | One-cycle pulse per downward step |
| ph_lo | output | 1 | Quadrature phase that is also the Gray LSB |
| ph_hi | output | 1 | Quadrature phase whose change triggers an upper-bit update |
| gray | output | N | Gray-coded count |
| bin | output | N | Binary count decoded from `gray` |

## Verification
The in-line assertions check every cycle that only one phase moves per step, that the up direction follows its successor rule, and that cancelled or idle cycles hold the phases. They also check that the upper Gray bits stay still unless a `ph_hi` change is pending, and that they never change more than one bit at a time.

The bench scenarios are needed for the rest. Only they show that the position and parity rule actually produces the right Gray value, that the values wrap correctly at both ends, and that the binary decode is correct. They also show the one-cycle lag of the upper bits and recovery after bursts of steps on consecutive cycles. These checks run over a 4-bit build with expected values computed from the net step count.

// File: rtl/quad_gray_counter.sv
module quad_gray_counter #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_up,
  input  logic         step_down,
  output logic         ph_lo,
  output logic         ph_hi,
  output logic [N-1:0] gray,
  output logic [N-1:0] bin
);

  localparam int TW = $clog2(N);

  logic [N-1:1]  upper;
  logic          hi_seen;
  logic [TW-1:0] tgt;
  logic          wval;

  wire move    = step_up ^ step_down;
  wire flip_lo = (ph_lo ~^ ph_hi) ^ step_down;
  wire pending = ph_hi ^ hi_seen;

  assign gray = {upper, ph_lo};

  always_comb begin
    tgt = TW'(N - 1);
    for (int i = N - 2; i >= 0; i--)
      if (gray[i]) tgt = TW'(i + 1);
    wval = (^upper) ^ upper[tgt] ^ ph_hi;
  end

  always_comb
    for (int i = 0; i < N; i++)
      bin[i] = ^(gray >> i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_lo   <= 1'b0;
      ph_hi   <= 1'b0;
      hi_seen <= 1'b0;
      upper   <= '0;
    end else begin
      if (move) begin
        if (flip_lo) ph_lo <= ~ph_lo;
        else         ph_hi <= ~ph_hi;
      end
      hi_seen <= ph_hi;
      if (pending) upper[tgt] <= wval;
    end
  end

  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    !((ph_lo != $past(ph_lo)) && (ph_hi != $past(ph_hi)))); // R3

  AST_UP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up && !step_down) |=> ((ph_lo != $past(ph_lo)) == ($past(ph_lo) == $past(ph_hi)))); // R2

  AST_HOLD_PHASES: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up == step_down) |=> ($stable(ph_lo) && $stable(ph_hi))); // R4

  AST_UPPER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    !pending |=> $stable(upper)); // R6

  AST_UPPER_ONEBIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(upper ^ $past(upper))); // R11

endmodule

// File: tb/quad_gray_counter_test.sv
module quad_gray_counter_test;
  localparam int N = 4;
  localparam int M = 1 << N;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic up = 1'b0;
  logic dn = 1'b0;
  logic ph_lo, ph_hi;
  logic [N-1:0] gray, bin;

  int errors = 0;
  int checks = 0;
  int pos = 0;

  quad_gray_counter #(.N(N)) uut (
    .clk(clk), .rst_n(rst_n), .step_up(up), .step_down(dn),
    .ph_lo(ph_lo), .ph_hi(ph_hi), .gray(gray), .bin(bin)
  );

  always #10 clk = ~clk;

  function automatic logic [N-1:0] gexp(int x);
    logic [N-1:0] v;
    v = N'(x);
    return v ^ (v >> 1);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    logic [N-1:0] v;
    logic [N-1:0] chain;
    v = N'(pos);
    check({req, " R8 gray"}, int'(gray), int'(gexp(pos)));
    check({req, " R2 R3 ph_lo"}, int'(ph_lo), int'(v[0] ^ v[1]));
    check({req, " R2 R3 ph_hi"}, int'(ph_hi), int'(v[1]));
    check({req, " R5 lsb"}, int'(gray[0]), int'(ph_lo));
    check({req, " R10 bin"}, int'(bin), int'(v));
    chain[N-1] = gray[N-1];
    for (int i = N - 2; i >= 0; i--) chain[i] = gray[i] ^ chain[i+1];
    check({req, " R10 chain"}, int'(bin), int'(chain));
  endtask

  task automatic step(bit u, bit d, string req);
    int nx;
    logic [N-1:0] oldg;
    logic [N-1:0] nv;
    oldg = gexp(pos);
    nx = (pos + (u && !d ? 1 : 0) - (d && !u ? 1 : 0) + M) % M;
    nv = N'(nx);
    @(negedge clk) begin up = u; dn = d; end
    @(negedge clk) begin up = 1'b0; dn = 1'b0; end
    check({req, " R2 R3 mid ph_hi"}, int'(ph_hi), int'(nv[1]));
    check({req, " R6 upper lag"}, int'(gray[N-1:1]), int'(oldg[N-1:1]));
    pos = nx;
    @(negedge clk);
    check_all({req, " R7"});
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [N-1:0] prev_up;
    repeat (3) @(negedge clk);
    check("R1 gray", int'(gray), 0);
    check("R1 bin", int'(bin), 0);
    check("R1 phases", int'({ph_lo, ph_hi}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 after reset");

    for (int k = 0; k < 2 * M + 3; k++) step(1'b1, 1'b0, "R2 R9 up");
    for (int k = 0; k < 3 * M; k++) step(1'b0, 1'b1, "R3 R9 down");

    step(1'b1, 1'b1, "R4 both");
    step(1'b0, 1'b0, "R4 idle");
    step(1'b0, 1'b1, "R9 down");
    step(1'b1, 1'b1, "R4 both");

    for (int r = 0; r < 6; r++) begin
      prev_up = gray;
      for (int i = 0; i < 40; i++) begin
        bit u, d;
        u = ((i + r) % 3) != 2;
        d = ((i * (r + 1)) % 5) == 0;
        @(negedge clk) begin up = u; dn = d; end
        pos = (pos + (u && !d ? 1 : 0) - (d && !u ? 1 : 0) + M) % M;
        check("R11 one upper bit", $countones((gray ^ prev_up) >> 1) <= 1 ? 1 : 0, 1);
        prev_up = gray;
      end
      @(negedge clk) begin up = 1'b0; dn = 1'b0; end
      @(negedge clk);
      @(negedge clk);
      check_all("R8 burst");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule